// File: doc/BRIEF.md
# Standby Wake-Up Stabilization Controller

This controller moves a small processor core between three power modes. In the operating mode the CPU clock runs. In the light sleep mode (HALT) only the CPU clock is gated and the oscillator keeps running. In the deep sleep mode (STOP) the oscillator itself is switched off. A core request puts the block into either sleep mode. An interrupt request wakes it. The block drives the CPU clock enable and the oscillator enable. It also drives a flag that tells the core whether to take the waking interrupt or to continue at the instruction after the standby instruction.

After a deep sleep the oscillator needs time to settle. The block counts a number of oscillator cycles before it gives the clock back to the CPU. Each oscillator cycle arrives as a pulse on `osc_tick`, and pulses only appear once oscillation has really started, so the time before oscillation begins is not counted. A 3-bit wait-select code picks one of four power-of-two counts. The other four code values are illegal. An illegal code raises an error flag and the block uses the longest count. Reset takes priority over every other input. It holds the oscillator on, waits a fixed count and then starts the core.

States: `ST_RSTWAIT` (reset stabilization), `ST_RUN` (operating), `ST_HALT`, `ST_STOP`, `ST_STAB` (stabilization after deep sleep). Transitions:
- RSTWAIT→RUN on the done pulse.
- RUN→STOP on a stop request.
- RUN→HALT on a halt request with no stop request.
- HALT→RUN on an interrupt request.
- STOP→STAB on an interrupt request.
- STAB→RUN on the done pulse.
- Any state→RSTWAIT on reset.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `osc_en`=1, `cpu_clk_en`=0, `vector_irq`=0 and `sel_err`=0, whatever state the block was in. After release, `cpu_clk_en` rises in the cycle after the 2^RST_EXP-th `osc_tick` pulse (default 2^17).
- R2: In the operating mode a `stop_req` makes `osc_en`=0 and `cpu_clk_en`=0 from the next cycle. When `stop_req` and `halt_req` arrive together, the stop request wins.
- R3: In the operating mode a `halt_req` alone makes `cpu_clk_en`=0 from the next cycle while `osc_en` stays 1.
- R4: In HALT an `irq` makes `cpu_clk_en`=1 in the next cycle, with no stabilization wait.
- R5: In STOP an `irq` turns `osc_en` back on in the next cycle. `cpu_clk_en` then rises in the cycle after the 2^E-th `osc_tick` pulse, where E comes from `wait_sel` sampled in the release cycle: 000→EXP_A (20), 011→EXP_B (17), 101→EXP_C (15), 111→EXP_D (13).
- R6: Cycles without an `osc_tick` pulse do not advance a stabilization wait. Changes to `wait_sel` after the release cycle do not alter the wait.
- R7: A prohibited code (001, 010, 100, 110) at STOP release sets `sel_err`=1 and gives the EXP_A wait. A legal code at a STOP release clears `sel_err`.
- R8: `vector_irq` takes the value of `ime` in the cycle the waking `irq` is accepted (HALT or STOP) and holds it until the next wake-up or reset.
- R9: `halt_req` and `stop_req` are ignored during both stabilization waits, including the final-tick cycle: the block still ends in the operating mode with `osc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, highest priority |
| halt_req | input | 1 | Request to enter light sleep |
| stop_req | input | 1 | Request to enter deep sleep |
| irq | input | 1 | Interrupt request that releases standby |
| ime | input | 1 | Interrupt master enable |
| wait_sel | input | 3 | Stabilization wait-select code |
| osc_tick | input | 1 | One pulse per live oscillator cycle |
| cpu_clk_en | output | 1 | CPU clock enable |
| osc_en | output | 1 | Oscillator enable |
| vector_irq | output | 1 | 1: service the interrupt after wake-up; 0: resume after the standby instruction |
| sel_err | output | 1 | Last STOP release used a prohibited code |

## Verification
Two events can fall in the same cycle: the terminal-count done pulse of a stabilization wait and a new sleep request from the core. The bench provokes this by driving random `halt_req`/`stop_req` values on every cycle of each wait, the final-tick cycle included. It then checks that the cycle after the last tick shows `cpu_clk_en`=1 with `osc_en`=1, meaning the request arrived too early to be accepted. A second clash, `halt_req` and `stop_req` raised in the same operating cycle, is judged by `osc_en` dropping in the next cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [2:0] {
        ST_RSTWAIT = 3'd0,
        ST_RUN     = 3'd1,
        ST_HALT    = 3'd2,
        ST_STOP    = 3'd3,
        ST_STAB    = 3'd4
    } stby_state_e;
endpackage

// File: rtl/stby_wait_decode.sv
// Maps the sparse wait-select code onto a power-of-two exponent.
module stby_wait_decode #(
    parameter int EXP_A = 20,
    parameter int EXP_B = 17,
    parameter int EXP_C = 15,
    parameter int EXP_D = 13,
    parameter int EW    = 5
) (
    input  logic [2:0]    code,
    output logic [EW-1:0] exp_o,
    output logic          bad_o
);
    always_comb begin
        bad_o = 1'b0;
        case (code)
            3'b000:  exp_o = EW'(EXP_A);
            3'b011:  exp_o = EW'(EXP_B);
            3'b101:  exp_o = EW'(EXP_C);
            3'b111:  exp_o = EW'(EXP_D);
            default: begin
                exp_o = EW'(EXP_A);   // fallback: longest wait
                bad_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/stby_stab_counter.sv
// Counts oscillator ticks up to 2^exp_sel; done pulses on the final tick.
module stby_stab_counter #(
    parameter int CW = 20,
    parameter int EW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [EW-1:0] exp_sel,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic [CW:0]   lim_full;

    always_comb begin
        lim_full = ((CW+1)'(1) << exp_sel) - (CW+1)'(1);
        done     = run && tick && (cnt == lim_full[CW-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || done)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import stby_pkg::*;
#(
    parameter int EXP_A   = 20,
    parameter int EXP_B   = 17,
    parameter int EXP_C   = 15,
    parameter int EXP_D   = 13,
    parameter int RST_EXP = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic       irq,
    input  logic       ime,
    input  logic [2:0] wait_sel,
    input  logic       osc_tick,
    output logic       cpu_clk_en,
    output logic       osc_en,
    output logic       vector_irq,
    output logic       sel_err
);
    localparam int CW = EXP_A;
    localparam int EW = $clog2(EXP_A + 1);

    stby_state_e   state, state_nxt;
    logic [EW-1:0] wait_exp;
    logic [EW-1:0] dec_exp;
    logic          dec_bad;
    logic          cnt_run;
    logic [EW-1:0] cnt_exp;
    logic          stab_done;
    logic          wake_acc;

    stby_wait_decode #(
        .EXP_A(EXP_A), .EXP_B(EXP_B), .EXP_C(EXP_C), .EXP_D(EXP_D), .EW(EW)
    ) u_dec (
        .code (wait_sel),
        .exp_o(dec_exp),
        .bad_o(dec_bad)
    );

    assign cnt_run = (state == ST_RSTWAIT) || (state == ST_STAB);
    assign cnt_exp = (state == ST_RSTWAIT) ? EW'(RST_EXP) : wait_exp;

    stby_stab_counter #(.CW(CW), .EW(EW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_run),
        .tick   (osc_tick),
        .exp_sel(cnt_exp),
        .done   (stab_done)
    );

    assign wake_acc = irq && ((state == ST_HALT) || (state == ST_STOP));

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RSTWAIT: if (stab_done) state_nxt = ST_RUN;
            ST_RUN: begin
                if (stop_req)      state_nxt = ST_STOP;
                else if (halt_req) state_nxt = ST_HALT;
            end
            ST_HALT:    if (irq) state_nxt = ST_RUN;
            ST_STOP:    if (irq) state_nxt = ST_STAB;
            ST_STAB:    if (stab_done) state_nxt = ST_RUN;
            default:    state_nxt = ST_RSTWAIT;
        endcase
    end

    // state and wake-up context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_RSTWAIT;
            wait_exp   <= EW'(EXP_A);
            vector_irq <= 1'b0;
            sel_err    <= 1'b0;
        end else begin
            state <= state_nxt;
            if (wake_acc)
                vector_irq <= ime;
            if (irq && (state == ST_STOP)) begin
                wait_exp <= dec_exp;
                sel_err  <= dec_bad;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        cpu_clk_en = (state == ST_RUN);
        osc_en     = (state != ST_STOP);
    end
endmodule

// File: rtl/stby_wake_chk.sv
module stby_wake_chk
    import stby_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        irq,
    input logic        cpu_clk_en,
    input logic        osc_en,
    input logic        vector_irq,
    input logic        done,
    input stby_state_e state
);
    // R2
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !cpu_clk_en);

    // R5
    stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !cpu_clk_en);

    // R5
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cpu_clk_en);

    // R4
    halt_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT && irq) |=> cpu_clk_en);

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STAB && !done) |=> !cpu_clk_en);

    // R8
    vector_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && $past(cpu_clk_en)) |-> $stable(vector_irq));
endmodule

bind stby_wake_ctrl stby_wake_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .cpu_clk_en(cpu_clk_en),
    .osc_en    (osc_en),
    .vector_irq(vector_irq),
    .done      (stab_done),
    .state     (state)
);

// File: tb/stby_wake_ctrl_tb.sv
module stby_wake_ctrl_tb;
    localparam int EA = 7;
    localparam int EB = 5;
    localparam int EC = 4;
    localparam int ED = 3;
    localparam int ER = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, stop_req = 1'b0, irq = 1'b0, ime = 1'b0;
    logic [2:0] wait_sel = 3'b000;
    logic       osc_tick = 1'b0;
    logic       cpu_clk_en, osc_en, vector_irq, sel_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    stby_wake_ctrl #(
        .EXP_A(EA), .EXP_B(EB), .EXP_C(EC), .EXP_D(ED), .RST_EXP(ER)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
        .irq(irq), .ime(ime), .wait_sel(wait_sel), .osc_tick(osc_tick),
        .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .vector_irq(vector_irq), .sel_err(sel_err)
    );

    function automatic int exp_of(input logic [2:0] c);
        case (c)
            3'b011:  return EB;
            3'b101:  return EC;
            3'b111:  return ED;
            default: return EA;
        endcase
    endfunction

    function automatic logic bad_of(input logic [2:0] c);
        return !(c == 3'b000 || c == 3'b011 || c == 3'b101 || c == 3'b111);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Count 2^e ticks with random tick gaps and random sleep requests; check
    // that the clock stays off until the cycle after the final tick (R5 R6 R9).
    task automatic run_wait(input int e, input string req);
        int need = 1 << e;
        int seen = 0;
        for (int g = 0; g < 4000 && seen < need; g++) begin
            osc_tick = (($urandom % 10) < 6);
            halt_req = $urandom % 2;
            stop_req = $urandom % 2;
            wait_sel = $urandom % 8;
            if (osc_tick) seen++;
            @(negedge clk);
            chk(osc_en == 1'b1, "R9", osc_en, 1);
            if (seen == need)
                chk(cpu_clk_en == 1'b1, req, cpu_clk_en, 1);
            else
                chk(cpu_clk_en == 1'b0, "R6", cpu_clk_en, 0);
        end
        osc_tick = 0; halt_req = 0; stop_req = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; halt_req = 0; stop_req = 0; irq = 0; osc_tick = 0;
        #1;
        // R1 asynchronous effect
        chk(osc_en == 1'b1, "R1", osc_en, 1);
        chk(cpu_clk_en == 1'b0, "R1", cpu_clk_en, 0);
        @(negedge clk); @(negedge clk);
        chk(vector_irq == 1'b0, "R1", vector_irq, 0);
        chk(sel_err == 1'b0, "R1", sel_err, 0);
        rst_n = 1'b1;
        run_wait(ER, "R1");
    endtask

    task automatic wake_stop(input logic [2:0] code, input logic m, input logic both);
        stop_req = 1'b1;
        halt_req = both;
        @(negedge clk);
        stop_req = 0; halt_req = 0;
        chk(osc_en == 1'b0, "R2", osc_en, 0);
        chk(cpu_clk_en == 1'b0, "R2", cpu_clk_en, 0);
        for (int k = 0; k < int'($urandom % 4); k++) begin
            osc_tick = $urandom % 2;
            @(negedge clk);
            chk(osc_en == 1'b0, "R2", osc_en, 0);
        end
        osc_tick = 0; irq = 1; ime = m; wait_sel = code;
        @(negedge clk);
        irq = 0; ime = ~m;
        chk(osc_en == 1'b1, "R5", osc_en, 1);
        chk(cpu_clk_en == 1'b0, "R5", cpu_clk_en, 0);
        run_wait(exp_of(code), bad_of(code) ? "R7" : "R5");
        chk(vector_irq == m, "R8", vector_irq, m);
        chk(sel_err == bad_of(code), "R7", sel_err, bad_of(code));
    endtask

    task automatic wake_halt(input logic m);
        halt_req = 1'b1;
        @(negedge clk);
        halt_req = 0;
        chk(cpu_clk_en == 1'b0, "R3", cpu_clk_en, 0);
        chk(osc_en == 1'b1, "R3", osc_en, 1);
        for (int k = 0; k < int'($urandom % 3); k++) begin
            osc_tick = $urandom % 2;
            @(negedge clk);
            chk(cpu_clk_en == 1'b0, "R3", cpu_clk_en, 0);
        end
        osc_tick = 0; irq = 1; ime = m;
        @(negedge clk);
        irq = 0; ime = ~m;
        chk(cpu_clk_en == 1'b1, "R4", cpu_clk_en, 1);
        chk(vector_irq == m, "R8", vector_irq, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        summary_and_end();
    end

    initial begin
        void'($urandom(32'h1d5e));
        @(negedge clk);
        do_reset();
        // directed: every code, both ime values (R5 R7 R8)
        for (int c = 0; c < 8; c++) begin
            wake_stop(3'(c), 1'b1, 1'b0);
            wake_stop(3'(c), 1'b0, 1'b0);
        end
        wake_halt(1'b1);
        wake_halt(1'b0);
        // R2: simultaneous halt and stop requests -> stop wins
        wake_stop(3'b111, 1'b1, 1'b1);
        // R1: reset while in STOP
        stop_req = 1;
        @(negedge clk);
        stop_req = 0;
        chk(osc_en == 1'b0, "R2", osc_en, 0);
        do_reset();
        // random mix
        for (int i = 0; i < 40; i++) begin
            if ($urandom % 3 == 0)
                wake_halt($urandom % 2);
            else
                wake_stop($urandom % 8, $urandom % 2, $urandom % 2);
        end
        summary_and_end();
    end
endmodule